// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Controller

This block is the bus-facing controller of a small byte-wide serial memory that answers on a two-wire bus. It runs on a fast system clock and oversamples the clock and data lines. Each line passes through a two-flop synchronizer and a majority-vote window, so short spikes are removed before any decoding. From the cleaned lines it finds start and stop conditions and takes in a control byte. For writes it also takes a word address and data bytes. It answers by pulling the data line low through an open-drain enable, both for acknowledges and for read data.

Write bytes go to an external page buffer as load strobes, each carrying an address and data. A stop after at least one data byte sends a single commit strobe, which starts the self-timed program cycle. While that cycle runs, the buffer raises a busy flag. The controller then refuses its control byte, so a host can poll for completion. Reads take bytes from the array at the address the block presents. The internal address counter keeps its value between transactions. A host can therefore read from the current position, or set the position first with a write that carries no data (a dummy write) and then issue a new start.

Top module: `twi_mem_target`

## Requirements
- R1: After reset the SDA pull-down is off, the address counter is 0 and no strobe is active. Bus activity is ignored until a start condition, which is an SDA fall while the filtered SCL is high.
- R2: The first byte after a start is acknowledged only when its upper four bits are 1010. Bit 0 selects read (1) or write (0). The acknowledge is SDA held low during the ninth SCL clock.
- R3: When sel_check_en_i is 1, control-byte bits 3..1 must equal dev_sel_i or the byte is not acknowledged and the bus is released until the next start. When sel_check_en_i is 0, those bits are not compared.
- R4: While prog_busy_i is 1, a control byte of either direction is not acknowledged.
- R5: In a write, the second byte loads the address counter and is acknowledged. Each later byte is acknowledged and gives a one-cycle wr_load_o with wr_addr_o equal to the counter. After each such byte, counter bits 3..0 increment and wrap within the 16-byte page while the upper bits stay fixed.
- R6: A stop that follows at least one loaded data byte gives exactly one one-cycle wr_commit_o pulse, never in the same cycle as wr_load_o. A write that ends with a new start, or a write that carries no data byte, commits nothing.
- R7: Read data is sent MSB first. Each bit changes only while SCL is low. Each byte is taken from rd_data_i at rd_addr_o, and the counter then increments over the full array, wrapping from 255 to 0.
- R8: A read that has no address phase starts at the counter value, which is the last accessed address plus one.
- R9: A host acknowledge (SDA low on the ninth clock) after a read byte causes the next byte to be sent. A host non-acknowledge leaves SDA released until the next start.
- R10: A write control byte and a word address, followed by a new start and a read control byte, reads from that word address.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_LEN/2+1 system clocks has no effect on the transfer.
- R12: The SDA pull-down is never switched on while the filtered SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| dev_sel_i | input | SEL_W | Strap value compared with control-byte bits 3..1 |
| sel_check_en_i | input | 1 | 1 enables the strap comparison |
| prog_busy_i | input | 1 | Page buffer is programming; refuse control bytes |
| rd_data_i | input | 8 | Array byte at rd_addr_o |
| sda_pull_o | output | 1 | Drives the data line low when 1 |
| wr_load_o | output | 1 | One-cycle strobe: write byte for the page buffer |
| wr_addr_o | output | ADDR_W | Address belonging to wr_load_o |
| wr_data_o | output | 8 | Data belonging to wr_load_o |
| wr_commit_o | output | 1 | One-cycle strobe: program the loaded bytes |
| rd_addr_o | output | ADDR_W | Address counter, used as the array read address |

## Verification
Selection is swept over every strap value against every select field with comparison on, and over every select field with comparison off. Wrong prefixes and a transfer without a start show that only a proper control byte gets an answer. A 20-byte page write that starts near the end of a page separates page wrapping from linear increment. A dummy-write read across address 255 separates full-array wrapping from page wrapping. A write abandoned by a new start, and control bytes sent while busy, show that commits and acknowledges are suppressed. Spikes of one and two system clocks on both lines, placed inside real bytes, show that the filter swallows them without corrupting the byte.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_HACK
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_CTRL,
    PH_WADDR,
    PH_WDATA
  } rx_ph_e;

  localparam logic [3:0] CTRL_PREFIX = 4'b1010;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
  parameter int unsigned FILT_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);
  localparam int unsigned HALF  = FILT_LEN / 2;

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] win_q;
  logic [CNT_W-1:0]    ones;
  logic                vote;

  always_comb begin
    ones = '0;
    for (int i = 0; i < FILT_LEN; i++) begin
      ones = ones + CNT_W'(win_q[i]);
    end
    vote = (ones > CNT_W'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      win_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[1]};
      line_o <= vote;
    end
  end
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_f;
      sda_prev <= sda_f;
    end
  end

  assign scl_rise   = scl_f & ~scl_prev;
  assign scl_fall   = ~scl_f & scl_prev;
  assign cond_start = scl_f & scl_prev & sda_prev & ~sda_f;
  assign cond_stop  = scl_f & scl_prev & ~sda_prev & sda_f;
endmodule

// File: rtl/twi_addr_counter.sv
module twi_addr_counter #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_W-1:0] col_next;

  assign col_next = addr_q[PAGE_W-1:0] + PAGE_W'(1);

  always_comb begin
    addr_d = addr_q;
    if (load_en) begin
      addr_d = load_val;
    end else if (inc_full) begin
      addr_d = addr_q + ADDR_W'(1);
    end else if (inc_page) begin
      addr_d = {addr_q[ADDR_W-1:PAGE_W], col_next};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_en | inc_full | inc_page) begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target
  import twi_mem_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned PAGE_W   = 4,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned FILT_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  dev_sel_i,
  input  logic              sel_check_en_i,
  input  logic              prog_busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_pull_o,
  output logic              wr_load_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int unsigned NLINES  = 2;
  localparam int unsigned CNT_W   = $clog2(BYTE_W + 1);
  localparam int unsigned SEL_LSB = 1;

  // line 1 = SCL, line 0 = SDA
  logic [NLINES-1:0] raw_lines, filt_lines;
  logic scl_lvl, sda_lvl;
  logic ev_rise, ev_fall, ev_start, ev_stop;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    twi_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  assign scl_lvl = filt_lines[1];
  assign sda_lvl = filt_lines[0];

  twi_bus_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f      (scl_lvl),
    .sda_f      (sda_lvl),
    .scl_rise   (ev_rise),
    .scl_fall   (ev_fall),
    .cond_start (ev_start),
    .cond_stop  (ev_stop)
  );

  // counter control
  logic              ctr_load, ctr_inc_page, ctr_inc_full;
  logic [ADDR_W-1:0] ctr_addr;

  // state
  bus_st_e           st_q, st_d;
  rx_ph_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              pull_q, pull_d;
  logic              dirty_q, dirty_d;
  logic              hack_q, hack_d;
  logic              load_q, load_d;
  logic              commit_q, commit_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [7:0]        wd_q, wd_d;
  logic              sel_ok;

  twi_addr_counter #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (ctr_load),
    .load_val (sh_q[ADDR_W-1:0]),
    .inc_page (ctr_inc_page),
    .inc_full (ctr_inc_full),
    .addr_o   (ctr_addr)
  );

  assign sel_ok = !sel_check_en_i || (sh_q[SEL_LSB+SEL_W-1:SEL_LSB] == dev_sel_i);

  always_comb begin
    st_d         = st_q;
    ph_d         = ph_q;
    cnt_d        = cnt_q;
    sh_d         = sh_q;
    rw_d         = rw_q;
    pull_d       = pull_q;
    dirty_d      = dirty_q;
    hack_d       = hack_q;
    load_d       = 1'b0;
    commit_d     = 1'b0;
    wa_d         = wa_q;
    wd_d         = wd_q;
    ctr_load     = 1'b0;
    ctr_inc_page = 1'b0;
    ctr_inc_full = 1'b0;

    if (ev_start) begin
      st_d    = ST_RECV;
      ph_d    = PH_CTRL;
      cnt_d   = '0;
      pull_d  = 1'b0;
      dirty_d = 1'b0;
    end else if (ev_stop) begin
      commit_d = dirty_q;
      dirty_d  = 1'b0;
      st_d     = ST_IDLE;
      pull_d   = 1'b0;
    end else begin
      unique case (st_q)
        ST_RECV: begin
          if (ev_rise && cnt_q < CNT_W'(BYTE_W)) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (ev_fall && cnt_q == CNT_W'(BYTE_W)) begin
            cnt_d = '0;
            unique case (ph_q)
              PH_CTRL: begin
                if (sh_q[7:4] == CTRL_PREFIX && sel_ok && !prog_busy_i) begin
                  pull_d = 1'b1;
                  rw_d   = sh_q[0];
                  st_d   = ST_ACK;
                end else begin
                  st_d = ST_IDLE;
                end
              end
              PH_WADDR: begin
                ctr_load = 1'b1;
                pull_d   = 1'b1;
                st_d     = ST_ACK;
              end
              default: begin
                load_d       = 1'b1;
                wa_d         = ctr_addr;
                wd_d         = sh_q;
                ctr_inc_page = 1'b1;
                dirty_d      = 1'b1;
                pull_d       = 1'b1;
                st_d         = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (ev_fall) begin
            if (ph_q == PH_CTRL && rw_q) begin
              sh_d         = rd_data_i;
              pull_d       = ~rd_data_i[7];
              ctr_inc_full = 1'b1;
              cnt_d        = '0;
              st_d         = ST_SEND;
            end else begin
              pull_d = 1'b0;
              st_d   = ST_RECV;
              ph_d   = (ph_q == PH_CTRL) ? PH_WADDR : PH_WDATA;
            end
          end
        end
        ST_SEND: begin
          if (ev_rise) begin
            cnt_d = cnt_q + CNT_W'(1);
          end else if (ev_fall) begin
            if (cnt_q == CNT_W'(BYTE_W)) begin
              pull_d = 1'b0;
              st_d   = ST_HACK;
            end else begin
              sh_d   = {sh_q[6:0], 1'b0};
              pull_d = ~sh_q[6];
            end
          end
        end
        ST_HACK: begin
          if (ev_rise) begin
            hack_d = ~sda_lvl;
          end else if (ev_fall) begin
            if (hack_q) begin
              sh_d         = rd_data_i;
              pull_d       = ~rd_data_i[7];
              ctr_inc_full = 1'b1;
              cnt_d        = '0;
              st_d         = ST_SEND;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: begin
          pull_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ph_q     <= PH_CTRL;
      cnt_q    <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      pull_q   <= 1'b0;
      dirty_q  <= 1'b0;
      hack_q   <= 1'b0;
      load_q   <= 1'b0;
      commit_q <= 1'b0;
      wa_q     <= '0;
      wd_q     <= '0;
    end else begin
      st_q     <= st_d;
      ph_q     <= ph_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      rw_q     <= rw_d;
      pull_q   <= pull_d;
      dirty_q  <= dirty_d;
      hack_q   <= hack_d;
      load_q   <= load_d;
      commit_q <= commit_d;
      if (load_d) begin
        wa_q <= wa_d;
        wd_q <= wd_d;
      end
    end
  end

  assign sda_pull_o  = pull_q;
  assign wr_load_o   = load_q;
  assign wr_addr_o   = wa_q;
  assign wr_data_o   = wd_q;
  assign wr_commit_o = commit_q;
  assign rd_addr_o   = ctr_addr;
endmodule

// File: rtl/twi_mem_target_chk.sv
module twi_mem_target_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              sda_pull,
  input logic              wr_load,
  input logic              wr_commit,
  input logic [ADDR_W-1:0] rd_addr
);
  assert_pull_on_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl);

  assert_addr_moves_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_addr) |-> !scl_lvl);

  assert_commit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  assert_load_commit_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_load, wr_commit}));

  assert_load_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |-> !scl_lvl);
endmodule

bind twi_mem_target twi_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .sda_pull  (sda_pull_o),
  .wr_load   (wr_load_o),
  .wr_commit (wr_commit_o),
  .rd_addr   (rd_addr_o)
);

// File: tb/twi_mem_target_test.sv
module twi_mem_target_test;
  localparam int QT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_scl = 1'b1;
  logic       host_sda = 1'b1;
  logic [2:0] pins = 3'd3;
  logic       chk_en = 1'b1;
  logic       busy = 1'b0;
  logic       sda_pull, wr_load, wr_commit;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  wire        sda_w = host_sda & ~sda_pull;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] pend_a [64];
  logic [7:0] pend_d [64];
  int         pend_n = 0;
  logic [7:0] ld_a [64];
  logic [7:0] ld_d [64];
  int         ld_n = 0;
  int         commit_n = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  assign rd_data = mem[rd_addr];

  twi_mem_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_w),
    .dev_sel_i(pins), .sel_check_en_i(chk_en), .prog_busy_i(busy),
    .rd_data_i(rd_data), .sda_pull_o(sda_pull), .wr_load_o(wr_load),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit),
    .rd_addr_o(rd_addr)
  );

  // page buffer model
  always @(posedge clk) begin
    if (wr_load) begin
      ld_a[ld_n % 64] = wr_addr;
      ld_d[ld_n % 64] = wr_data;
      ld_n = ld_n + 1;
      pend_a[pend_n % 64] = wr_addr;
      pend_d[pend_n % 64] = wr_data;
      pend_n = pend_n + 1;
    end
    if (wr_commit) begin
      for (int k = 0; k < pend_n && k < 64; k++) mem[pend_a[k]] = pend_d[k];
      pend_n = 0;
      commit_n = commit_n + 1;
    end
  end

  function automatic logic [7:0] seed(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(int act, int exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    pend_n = 0;
    host_sda = 1'b1; tick(QT);
    host_scl = 1'b1; tick(QT);
    host_sda = 1'b0; tick(QT);
    host_scl = 1'b0; tick(QT);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(QT);
    host_scl = 1'b1; tick(QT);
    host_sda = 1'b1; tick(2 * QT);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glen, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; tick(QT);
      host_scl = 1'b1;
      if (glen > 0 && i == 3) begin
        tick(QT); host_scl = 1'b0; tick(glen); host_scl = 1'b1; tick(QT - glen);
      end else if (glen > 0 && i == 5 && b[5]) begin
        tick(QT); host_sda = 1'b0; tick(glen); host_sda = 1'b1; tick(QT - glen);
      end else begin
        tick(2 * QT);
      end
      host_scl = 1'b0; tick(QT);
    end
    host_sda = 1'b1; tick(QT);
    host_scl = 1'b1; tick(QT);
    acked = ~sda_w;
    tick(QT);
    host_scl = 1'b0; tick(QT);
  endtask

  task automatic recv_byte(input logic hack, output logic [7:0] b, output logic steady);
    steady = 1'b1;
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(2 * QT);
      host_scl = 1'b1; tick(QT);
      b[i] = sda_w; tick(QT);
      if (sda_w !== b[i]) steady = 1'b0;
      host_scl = 1'b0;
    end
    tick(QT);
    host_sda = ~hack; tick(QT);
    host_scl = 1'b1; tick(2 * QT);
    host_scl = 1'b0; tick(QT);
    host_sda = 1'b1;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic       stdy;
    logic [7:0] rb;
    int         c0, l0;
    for (int a = 0; a < 256; a++) begin
      mem[a] = seed(a);
      exp_mem[a] = seed(a);
    end
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state and no answer without a start
    check(sda_pull, 0, "R1", "pull after reset");
    check(rd_addr, 0, "R1", "counter after reset");
    check({wr_load, wr_commit}, 0, "R1", "strobes after reset");
    send_byte(8'hA6, 0, ack);
    check(ack, 0, "R1", "ack without start");

    // R2: wrong prefixes
    bus_start(); send_byte(8'hB6, 0, ack); bus_stop();
    check(ack, 0, "R2", "prefix 1011");
    bus_start(); send_byte(8'h26, 0, ack); bus_stop();
    check(ack, 0, "R2", "prefix 0010");

    // R3: select sweep, comparison on
    for (int p = 0; p < 8; p++) begin
      for (int h = 0; h < 8; h++) begin
        pins = 3'(p);
        bus_start(); send_byte({4'b1010, 3'(h), 1'b0}, 0, ack); bus_stop();
        check(ack, (p == h) ? 1 : 0, "R3", $sformatf("sel pins=%0d field=%0d", p, h));
      end
    end
    // R3: comparison off
    chk_en = 1'b0; pins = 3'd3;
    for (int h = 0; h < 8; h++) begin
      bus_start(); send_byte({4'b1010, 3'(h), 1'b0}, 0, ack); bus_stop();
      check(ack, 1, "R3", $sformatf("no compare field=%0d", h));
    end
    chk_en = 1'b1;
    check(commit_n, 0, "R6", "no commit without data");

    // R5 R6: byte write
    l0 = ld_n;
    bus_start(); send_byte(8'hA6, 0, ack); send_byte(8'h12, 0, ack);
    check(ack, 1, "R5", "word address ack");
    send_byte(8'h5A, 0, ack);
    check(ack, 1, "R5", "data ack");
    bus_stop(); tick(4);
    exp_mem[8'h12] = 8'h5A;
    check(commit_n, 1, "R6", "byte write commit");
    check(ld_n - l0, 1, "R5", "byte write loads");
    check(ld_a[l0 % 64], 8'h12, "R5", "byte write addr");
    check(ld_d[l0 % 64], 8'h5A, "R5", "byte write data");

    // R5: page write of 20 bytes from column 0xC
    l0 = ld_n;
    bus_start(); send_byte(8'hA6, 0, ack); send_byte(8'h3C, 0, ack);
    for (int i = 0; i < 20; i++) begin
      send_byte(8'((i * 13 + 64) & 255), 0, ack);
      check(ack, 1, "R5", $sformatf("page byte %0d ack", i));
      check(ld_a[(l0 + i) % 64], 8'h30 | ((12 + i) & 15), "R5", $sformatf("page addr %0d", i));
      exp_mem[8'h30 | ((12 + i) & 15)] = 8'((i * 13 + 64) & 255);
    end
    bus_stop(); tick(4);
    check(commit_n, 2, "R6", "page commit");

    // R8: current address read, counter now 0x30
    bus_start(); send_byte(8'hA7, 0, ack);
    check(ack, 1, "R2", "read control ack");
    recv_byte(1'b0, rb, stdy); bus_stop();
    check(rb, exp_mem[8'h30], "R8", "current address byte");
    check(stdy, 1, "R7", "bits steady while SCL high");

    // R10 R7 R9: dummy write to 0xFE then sequential read over wrap
    bus_start(); send_byte(8'hA6, 0, ack); send_byte(8'hFE, 0, ack);
    bus_start(); send_byte(8'hA7, 0, ack);
    for (int i = 0; i < 4; i++) begin
      recv_byte((i < 3) ? 1'b1 : 1'b0, rb, stdy);
      check(rb, exp_mem[(254 + i) & 255], "R10", $sformatf("sequential byte %0d", i));
      check(stdy, 1, "R7", $sformatf("steady byte %0d", i));
    end
    tick(2 * QT);
    check(sda_pull, 0, "R9", "released after host NAK");
    host_scl = 1'b1; tick(2 * QT);
    check(sda_pull, 0, "R9", "still released on extra clock");
    host_scl = 1'b0; tick(QT);
    bus_stop(); tick(4);
    check(commit_n, 2, "R6", "dummy write no commit");
    check(rd_addr, 2, "R7", "counter wrapped to 2");

    // R6: write abandoned by a new start
    c0 = commit_n;
    bus_start(); send_byte(8'hA6, 0, ack); send_byte(8'h80, 0, ack); send_byte(8'h11, 0, ack);
    bus_start(); send_byte(8'hA7, 0, ack);
    recv_byte(1'b0, rb, stdy); bus_stop(); tick(4);
    check(commit_n, c0, "R6", "abandoned write no commit");
    check(rb, exp_mem[8'h81], "R8", "read after abandoned write");

    // R4: busy refuses both directions
    busy = 1'b1;
    bus_start(); send_byte(8'hA6, 0, ack); bus_stop();
    check(ack, 0, "R4", "write ctrl while busy");
    bus_start(); send_byte(8'hA7, 0, ack); bus_stop();
    check(ack, 0, "R4", "read ctrl while busy");
    busy = 1'b0;
    bus_start(); send_byte(8'hA6, 0, ack); bus_stop();
    check(ack, 1, "R4", "ctrl after busy clears");

    // R11: spikes of 1 and 2 clocks inside bytes
    l0 = ld_n;
    bus_start(); send_byte(8'hA6, 2, ack);
    check(ack, 1, "R11", "ctrl with spikes");
    send_byte(8'h20, 2, ack);
    send_byte(8'hA5, 1, ack);
    check(ack, 1, "R11", "data with spikes");
    bus_stop(); tick(4);
    check(ld_a[l0 % 64], 8'h20, "R11", "spiked address");
    check(ld_d[l0 % 64], 8'hA5, "R11", "spiked data");
    exp_mem[8'h20] = 8'hA5;
    bus_start(); send_byte(8'hA6, 0, ack); send_byte(8'h20, 0, ack);
    bus_start(); send_byte(8'hA7, 0, ack);
    recv_byte(1'b1, rb, stdy);
    check(rb, exp_mem[8'h20], "R11", "readback spiked write");
    recv_byte(1'b0, rb, stdy); bus_stop();
    check(rb, exp_mem[8'h21], "R9", "host ack gave next byte");
    check(exp_mem[8'h80], seed(8'h80), "R6", "abandoned byte untouched");
    bus_start(); send_byte(8'hA6, 0, ack); send_byte(8'h80, 0, ack);
    bus_start(); send_byte(8'hA7, 0, ack);
    recv_byte(1'b0, rb, stdy); bus_stop();
    check(rb, seed(8'h80), "R6", "array at abandoned address");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule